// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects level requests from 28 interrupt sources into a pending latch, masks them with a software enable word and selects one winner. Every source except source 0 has its own 3-bit priority level. The block drives a single registered interrupt line to the processor. A vector word returns the winner's index next to a 16-bit software base, so a handler can find its service routine by direct lookup instead of by polling.

When nesting is switched on, the controller records the level of each request that software acknowledges in an in-service mask. It then raises the line again only for a request whose level is strictly more urgent than the most urgent level still in service. An end-of-service write retires that level. Software uses the block through a small word-addressed register bus with a combinational read path.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every register (word addresses 0 to 11) reads 0 and `irq` is low.
- R2: Source s has a level field at word address 8 + s/8, in bits [4*(s%8)+2 : 4*(s%8)]. Bit 3 of every nibble reads 0. The nibble of source 0, and any nibble with no source behind it, always reads 0.
- R3: The vector word at address 3 reads the base (address 4, 16 bits) in bits [22:7] and the winner index in bits [6:2]. Bits [31:23] and [1:0] read 0, and the index reads 0 when no enabled source is pending.
- R4: The winner is the enabled pending source with the smallest level number, where 0 is the most urgent. A tie goes to the lower index. Source 0 is fixed at level 0, so it wins every tie.
- R5: A high `req_in` bit sets its pending bit, which address 2 reads back. Writing 1s to address 2 clears those bits, but a request that is still high keeps its bit set. A source whose bit in the enable word (address 1) is 0 produces neither `irq` nor a vector index.
- R6: With nesting off (address 0 bit 0 = 0), `irq` is high one clock after any enabled source is pending, and a read of the vector word leaves the in-service state unchanged.
- R7: With nesting on, a read of the vector word while the winner may interrupt marks the winner's level as in service. After that, `irq` is raised only for a winner whose level number is strictly below the lowest in-service level number.
- R8: Any write to address 5 takes the most urgent level out of service, so a blocked less urgent request interrupts again once all more urgent levels have been retired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Register word address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; a strobed vector read acknowledges the winner |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| req_in | input | 28 | Raw level request per source |
| irq | output | 1 | Registered interrupt request to the processor |

## Verification
The hardest state to reach from the ports is a less urgent request held back by two stacked in-service levels. The bench reaches it in steps. It raises a level-1 source and acknowledges it with a vector read, then leaves a level-3 request pending so that it is blocked. It then raises and acknowledges a level-0 source. Finally it issues two end-of-service writes and checks that the line stays low after the first write and rises only after the second.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NSRC  = 28,
  parameter int LVLW  = 3,
  parameter int BASEW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      addr,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  input  logic [NSRC-1:0] req_in,
  output logic            irq
);
  localparam int IDXW  = $clog2(NSRC);
  localparam int NLVL  = 1 << LVLW;
  localparam int NPREG = (NSRC + 7) / 8;
  localparam logic [3:0] A_CFG = 4'd0, A_EN = 4'd1, A_PEND = 4'd2, A_VEC = 4'd3,
                         A_BASE = 4'd4, A_EOI = 4'd5, A_PRIO = 4'd8;

  logic             nest;
  logic [NSRC-1:0]  en, pend, act;
  logic [BASEW-1:0] base;
  logic [NLVL-1:0]  isv;
  logic [LVLW-1:0]  lvl [NSRC];
  logic [31:0]      prio_word [NPREG];

  logic [IDXW-1:0]  win_idx;
  logic [LVLW-1:0]  win_lvl, top_lvl;
  logic             found, isv_any, irq_d, ack, eoi;
  logic [31:0]      vec;

  assign act = pend & en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nest <= 1'b0;
      en   <= '0;
      base <= '0;
      pend <= '0;
    end else begin
      if (wr_en && addr == A_CFG)  nest <= wdata[0];
      if (wr_en && addr == A_EN)   en   <= wdata[NSRC-1:0];
      if (wr_en && addr == A_BASE) base <= wdata[BASEW-1:0];
      pend <= (pend & ~((wr_en && addr == A_PEND) ? wdata[NSRC-1:0] : '0)) | req_in;
    end
  end

  assign lvl[0] = '0;
  for (genvar s = 1; s < NSRC; s++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (!rst_n)
        lvl[s] <= '0;
      else if (wr_en && addr == A_PRIO + 4'(s / 8))
        lvl[s] <= wdata[4*(s%8) +: LVLW];
    end
  end

  for (genvar r = 0; r < NPREG; r++) begin : g_pword
    always_comb begin
      prio_word[r] = '0;
      for (int s = 8*r; s < 8*r + 8 && s < NSRC; s++)
        prio_word[r][4*(s%8) +: LVLW] = lvl[s];
    end
  end

  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    win_lvl = '1;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (act[i] && (!found || lvl[i] <= win_lvl)) begin
        found   = 1'b1;
        win_lvl = lvl[i];
        win_idx = IDXW'(i);
      end
    end
  end

  always_comb begin
    isv_any = 1'b0;
    top_lvl = '0;
    for (int l = NLVL - 1; l >= 0; l--) begin
      if (isv[l]) begin
        isv_any = 1'b1;
        top_lvl = LVLW'(l);
      end
    end
  end

  assign irq_d = found && (!nest || !isv_any || win_lvl < top_lvl);
  assign ack   = rd_en && addr == A_VEC && nest && irq_d;
  assign eoi   = wr_en && addr == A_EOI;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isv <= '0;
      irq <= 1'b0;
    end else begin
      irq <= irq_d;
      if (eoi && isv_any) isv[top_lvl] <= 1'b0;
      if (ack)            isv[win_lvl] <= 1'b1;
    end
  end

  assign vec = 32'({base, win_idx, 2'b00});

  always_comb begin
    rdata = '0;
    case (addr)
      A_CFG:  rdata = {31'b0, nest};
      A_EN:   rdata = 32'(en);
      A_PEND: rdata = 32'(pend);
      A_VEC:  rdata = vec;
      A_BASE: rdata = 32'(base);
      default: begin
        for (int r = 0; r < NPREG; r++)
          if (addr == A_PRIO + 4'(r)) rdata = prio_word[r];
      end
    endcase
  end
endmodule

module prio_irq_ctrl_chk #(
  parameter int NSRC = 28,
  parameter int NLVL = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [3:0]      addr,
  input logic            wr_en,
  input logic [31:0]     rdata,
  input logic [NSRC-1:0] req_in,
  input logic [NSRC-1:0] pend,
  input logic [NSRC-1:0] en,
  input logic            nest,
  input logic [NLVL-1:0] isv,
  input logic            irq
);
  // R6
  quiet_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & en) == '0) |=> !irq);
  // R3
  vec_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 4'd3) |-> (rdata[1:0] == 2'b00 && rdata[31:23] == '0));
  // R2
  prio_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr >= 4'd8) |-> ((rdata & 32'h8888_8888) == '0 && rdata[3:0] == 4'h0 || addr != 4'd8));
  // R5
  req_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(req_in)) == $past(req_in)));
  // R7
  top_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nest && isv[0]) |=> !irq);
  // R8
  eoi_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'd5 && isv != '0) |=> ($countones(isv) == $past($countones(isv)) - 1));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NSRC(NSRC), .NLVL(NLVL)) chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rdata(rdata),
  .req_in(req_in), .pend(pend), .en(en), .nest(nest), .isv(isv), .irq(irq)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [27:0] req_in = '0;
  logic        irq;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  prio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .req_in(req_in), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; addr = '0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic ack_read(output logic [31:0] d);
    @(negedge clk); addr = 4'd3; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0; addr = '0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_req(logic [27:0] m);
    @(negedge clk); req_in = m;
    @(negedge clk); req_in = '0;
    settle();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", 32'(irq), 0);
    for (int a = 0; a < 12; a++) begin
      rd(4'(a), d);
      chk("R1 reg", d, 0);
    end
  endtask

  task automatic t_prio();
    logic [31:0] d;
    wr(4'd8, 32'hFFFF_FFFF);  rd(4'd8, d);  chk("R2 word8", d, 32'h7777_7770);
    wr(4'd11, 32'hFFFF_FFFF); rd(4'd11, d); chk("R2 word11", d, 32'h0000_7777);
    wr(4'd9, 32'h89AB_CDEF);  rd(4'd9, d);  chk("R2 word9", d, 32'h0123_4567);
    wr(4'd11, 32'h0);
    wr(4'd8, 32'h0235_2000);
    wr(4'd9, 32'h0000_0010);
  endtask

  task automatic t_vector();
    logic [31:0] d;
    wr(4'd4, 32'h0000_ABCD);
    wr(4'd1, 32'h10);
    @(negedge clk); req_in = 28'h10; settle();
    chk("R6 irq on", 32'(irq), 1);
    rd(4'd3, d); chk("R3 vector", d, 32'h0055_E690);
    chk("R3 index", 32'(d[6:2]), 4);
    @(negedge clk); req_in = '0;
    wr(4'd2, 32'h0FFF_FFFF); settle();
    chk("R6 irq off", 32'(irq), 0);
    rd(4'd3, d); chk("R3 idle vector", d, 32'h0055_E680);
  endtask

  task automatic t_arb();
    logic [31:0] d;
    wr(4'd1, 32'h220);
    pulse_req(28'h220);
    rd(4'd3, d); chk("R4 level", 32'(d[6:2]), 9);
    wr(4'd2, 32'h0FFF_FFFF);
    wr(4'd1, 32'h68);
    pulse_req(28'h68);
    rd(4'd3, d); chk("R4 tie", 32'(d[6:2]), 3);
    wr(4'd2, 32'h0FFF_FFFF);
    wr(4'd1, 32'h1001);
    pulse_req(28'h1001);
    rd(4'd3, d); chk("R4 source0", 32'(d[6:2]), 0);
    wr(4'd2, 32'h0FFF_FFFF);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(4'd1, 32'h10);
    pulse_req(28'h80);
    rd(4'd2, d); chk("R5 pending", d, 32'h80);
    chk("R5 masked irq", 32'(irq), 0);
    rd(4'd3, d); chk("R5 masked index", 32'(d[6:2]), 0);
    wr(4'd2, 32'h80); settle();
    rd(4'd2, d); chk("R5 cleared", d, 0);
    @(negedge clk); req_in = 28'h80;
    wr(4'd2, 32'h80); settle();
    rd(4'd2, d); chk("R5 held", d, 32'h80);
    @(negedge clk); req_in = '0;
    wr(4'd2, 32'h0FFF_FFFF);
  endtask

  task automatic t_nest();
    logic [31:0] d;
    wr(4'd0, 32'h1);
    wr(4'd1, 32'h1220);
    pulse_req(28'h200);
    chk("R7 first irq", 32'(irq), 1);
    ack_read(d); chk("R7 ack index", 32'(d[6:2]), 9);
    settle();
    chk("R7 same level blocked", 32'(irq), 0);
    wr(4'd2, 32'h200);
    pulse_req(28'h20);
    chk("R7 lower blocked", 32'(irq), 0);
    pulse_req(28'h1000);
    chk("R7 preempt", 32'(irq), 1);
    ack_read(d); chk("R7 preempt index", 32'(d[6:2]), 12);
    wr(4'd2, 32'h1000); settle();
    chk("R7 stacked blocked", 32'(irq), 0);
    wr(4'd5, 32'h0); settle();
    chk("R8 one eoi", 32'(irq), 0);
    wr(4'd5, 32'h0); settle();
    chk("R8 two eoi", 32'(irq), 1);
  endtask

  task automatic t_nonest();
    logic [31:0] d;
    wr(4'd0, 32'h0);
    ack_read(d); settle();
    chk("R6 no ack", 32'(irq), 1);
    wr(4'd0, 32'h1); settle();
    chk("R6 isv empty", 32'(irq), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prio();
    t_vector();
    t_arb();
    t_mask();
    t_nest();
    t_nonest();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule